// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block chooses which of six masters may drive a shared parallel bus. Five masters sit outside the chip and one is internal, and each has its own request line and grant line. A configuration bit per master puts that master in a high-priority pool or a low-priority pool. The high pool rotates round-robin. The low pool also rotates among its own members, but none of them competes directly. Instead the next requesting low member is promoted into the high rotation, where it competes as an ordinary high member. Once it wins the bus it drops back into the low pool, and the following low member takes the promoted slot. Masters in the low pool therefore get a fair share of the bus without delaying the high pool for more than one turn in each rotation.

A new grant is chosen only in a cycle where the bus is reported idle. While the bus is busy the current grant is held. When no master requests, the grant parks on the internal master. A global enable switches the arbiter off so that an outside arbiter can take over, and while it is off every grant line is released. Requests and grants are active-low. Grants are registered, so a decision made from the inputs sampled at one rising edge appears on the grant lines just after that edge.

Top module: `arb_two_level`

## Requirements
- R1: While reset is asserted, and immediately after it, every bit of gnt_n is 1 (no grant).
- R2: At most one bit of gnt_n is 0 at any time.
- R3: When arb_en is 0 at a rising edge, every bit of gnt_n is 1 after that edge, whatever the requests.
- R4: When arb_en is 1 and bus_idle is 0 at a rising edge, gnt_n keeps its value across that edge.
- R5: When arb_en and bus_idle are 1 and every bit of req_n is 1, the grant goes to the internal master, bit 5 (gnt_n = 6'b011111).
- R6: When arb_en and bus_idle are 1 and at least one request is present (req_n bit 0 means "requesting"), the master granted after the edge is one that was requesting.
- R7: Master i is in the high pool when pool_hi[i] is 1 and in the low pool when it is 0. The candidate set is every requesting high master plus the promoted member, which is the first requesting low master found by scanning upward, with wrap, from the low pointer. The winner is the first candidate found by scanning upward, with wrap, from the high pointer. Both pointers are 0 after reset.
- R8: After a win, the high pointer moves to the winner's index plus one (5 wraps to 0). With all six masters in the high pool and all requesting, grants therefore cycle 0,1,2,3,4,5,0,...
- R9: When the promoted low member wins, the low pointer moves to its index plus one (with wrap). Otherwise the low pointer does not move. Starting from reset pointers, with only master 0 in the high pool and masters 0, 1 and 2 requesting, the grants run 0,1,2,0,1,2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling happens on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | 1 = arbiter active; 0 = all grants released so an outside arbiter can take over |
| bus_idle | input | 1 | 1 = bus free, so a new grant may be chosen |
| pool_hi | input | 6 | Per-master pool select, 1 = high pool, 0 = low pool; bit 5 is the internal master |
| req_n | input | 6 | Active-low requests; bits 0..4 are external masters, bit 5 is the internal master |
| gnt_n | output | 6 | Active-low one-hot registered grants, same bit order as req_n |

## Verification
The hardest situation to reach is a promoted low member winning while high members keep requesting. After that win, both pointers sit at positions that can only be reached through a particular history of wins. Wrong demotion or pointer movement therefore shows up only several grants later. The stimulus gets there with a directed pattern of one high master against two low masters, all requesting, whose grant order is known in advance. It then sweeps all 64 pool settings with pseudo-random requests, bus-idle cycles and enable cycles, while an arithmetic reference keeps its own pointer pair.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // What the grant register does on the coming edge
    typedef enum logic [1:0] {
        ACT_OFF  = 2'd0,
        ACT_HOLD = 2'd1,
        ACT_PARK = 2'd2,
        ACT_WIN  = 2'd3
    } arb_act_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Rotating-priority picker: first set bit of mask at or above ptr, with wrap.
module arb_rr_pick #(
    parameter int N  = 6,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = int'(ptr) + k;
            if (pos >= N) pos = pos - N;
            if (!found && mask[pos]) begin
                found       = 1'b1;
                idx         = IW'(pos);
                onehot[pos] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb_two_level.sv
module arb_two_level #(
    parameter int N_EXT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_en,
    input  logic             bus_idle,
    input  logic [N_EXT:0]   pool_hi,
    input  logic [N_EXT:0]   req_n,
    output logic [N_EXT:0]   gnt_n
);
    import arb_pkg::*;

    localparam int N       = N_EXT + 1;
    localparam int IW      = $clog2(N);
    localparam int INT_IDX = N - 1;

    typedef struct packed {
        logic [N-1:0]  gnt;
        logic [IW-1:0] hi_ptr;
        logic [IW-1:0] lo_ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N-1:0]  req_act;
    logic [N-1:0]  lo_mask;
    logic [N-1:0]  hi_mask;
    logic          lo_found, hi_found;
    logic [IW-1:0] lo_idx, hi_idx;
    logic [N-1:0]  lo_oh, hi_oh;
    arb_act_e      act;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
        return (int'(v) == N - 1) ? '0 : v + 1'b1;
    endfunction

    assign req_act = ~req_n;
    assign lo_mask = req_act & ~pool_hi;
    // high rotation sees its own members plus the single promoted low member
    assign hi_mask = (req_act & pool_hi) | lo_oh;

    arb_rr_pick #(.N(N), .IW(IW)) u_lo_pick (
        .mask   (lo_mask),
        .ptr    (st_q.lo_ptr),
        .found  (lo_found),
        .idx    (lo_idx),
        .onehot (lo_oh)
    );

    arb_rr_pick #(.N(N), .IW(IW)) u_hi_pick (
        .mask   (hi_mask),
        .ptr    (st_q.hi_ptr),
        .found  (hi_found),
        .idx    (hi_idx),
        .onehot (hi_oh)
    );

    always_comb begin
        if (!arb_en)        act = ACT_OFF;
        else if (!bus_idle) act = ACT_HOLD;
        else if (!hi_found) act = ACT_PARK;
        else                act = ACT_WIN;
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_OFF:  st_d.gnt = '0;
            ACT_HOLD: st_d.gnt = st_q.gnt;
            ACT_PARK: begin
                st_d.gnt          = '0;
                st_d.gnt[INT_IDX] = 1'b1;
            end
            ACT_WIN: begin
                st_d.gnt    = hi_oh;
                st_d.hi_ptr = wrap_inc(hi_idx);
                // promoted member won: demote it and hand the slot onward
                if (lo_found && (lo_idx == hi_idx)) begin
                    st_d.lo_ptr = wrap_inc(lo_idx);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_n = ~st_q.gnt;

endmodule

// File: rtl/arb_two_level_chk.sv
module arb_two_level_chk #(
    parameter int N = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         arb_en,
    input logic         bus_idle,
    input logic [N-1:0] req_n,
    input logic [N-1:0] gnt_n
);
    localparam int INT_IDX = N - 1;

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    assert_off_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> (&gnt_n));

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && !bus_idle) |=> $stable(gnt_n));

    assert_park_internal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && bus_idle && (&req_n)) |=> (gnt_n == ~(N'(1) << INT_IDX)));

    assert_grant_requester_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && bus_idle && !(&req_n)) |=> ((~gnt_n & ~$past(req_n)) != '0));

endmodule

bind arb_two_level arb_two_level_chk #(.N(N_EXT + 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb_en   (arb_en),
    .bus_idle (bus_idle),
    .req_n    (req_n),
    .gnt_n    (gnt_n)
);

// File: tb/sim_arb_two_level.sv
`timescale 1ns/1ps
module sim_arb_two_level;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_en = 1'b0;
    logic       bus_idle = 1'b0;
    logic [5:0] pool_hi = '0;
    logic [5:0] req_n = 6'h3f;
    logic [5:0] gnt_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    int         m_hi = 0;
    int         m_lo = 0;
    logic [5:0] m_gnt = '0;
    logic [15:0] lfsr = 16'hace1;

    always #2.5 clk = ~clk;

    arb_two_level u0 (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .bus_idle(bus_idle),
        .pool_hi(pool_hi), .req_n(req_n), .gnt_n(gnt_n)
    );

    task automatic check(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // reference model of R3..R9
    task automatic model(input logic en, input logic idle, input logic [5:0] hi, input logic [5:0] req);
        int cand, w;
        if (!en) m_gnt = '0;
        else if (idle) begin
            cand = -1;
            w = -1;
            for (int k = 0; k < 6; k++) begin
                int p = (m_lo + k) % 6;
                if (cand < 0 && !hi[p] && req[p]) cand = p;
            end
            for (int k = 0; k < 6; k++) begin
                int p = (m_hi + k) % 6;
                if (w < 0 && ((hi[p] && req[p]) || p == cand)) w = p;
            end
            if (w < 0) m_gnt = 6'b100000;
            else begin
                m_gnt = 6'(1) << w;
                m_hi = (w + 1) % 6;
                if (w == cand) m_lo = (w + 1) % 6;
            end
        end
    endtask

    task automatic step(input logic en, input logic idle, input logic [5:0] hi, input logic [5:0] req);
        string tag;
        arb_en = en; bus_idle = idle; pool_hi = hi; req_n = ~req;
        model(en, idle, hi, req);
        if (!en) tag = "R3";
        else if (!idle) tag = "R4";
        else if (req == 0) tag = "R5";
        else tag = "R7";
        @(posedge clk);
        @(negedge clk);
        check(gnt_n == ~m_gnt, tag, gnt_n, ~m_gnt);
        check($countones(~gnt_n) <= 1, "R2", gnt_n, ~m_gnt);
        if (en && idle && req != 0)
            check((~gnt_n & req) != 0, "R6", gnt_n, ~m_gnt);
    endtask

    initial begin
        arb_en = 1'b1; bus_idle = 1'b1; req_n = 6'h00; pool_hi = 6'h3f;
        repeat (3) @(negedge clk);
        check(gnt_n == 6'h3f, "R1", gnt_n, 6'h3f);
        rst_n = 1'b1;
        check(gnt_n == 6'h3f, "R1", gnt_n, 6'h3f);

        // R8: all high, all requesting -> plain rotation
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 1'b1, 6'h3f, 6'h3f);
            check(gnt_n == ~(6'(1) << (i % 6)), "R8", gnt_n, ~(6'(1) << (i % 6)));
        end

        // R9: one high master vs two low masters
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b1, 6'b000001, 6'b000111);
            check(gnt_n == ~(6'(1) << (i % 3)), "R9", gnt_n, ~(6'(1) << (i % 3)));
        end

        // R5 directed: nobody requests
        step(1'b1, 1'b1, 6'h15, 6'h00);
        check(gnt_n == 6'b011111, "R5", gnt_n, 6'b011111);
        // R4 directed: busy with new requests keeps park
        step(1'b1, 1'b0, 6'h15, 6'h0f);
        check(gnt_n == 6'b011111, "R4", gnt_n, 6'b011111);
        // R3 directed: disabled with requests
        step(1'b0, 1'b1, 6'h15, 6'h3f);
        check(gnt_n == 6'h3f, "R3", gnt_n, 6'h3f);

        // sweep all pool settings with pseudo-random traffic
        for (int cfg = 0; cfg < 64; cfg++) begin
            for (int c = 0; c < 40; c++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[7:4] != 4'h0, lfsr[3:2] != 2'b00, 6'(cfg), lfsr[15:10] & lfsr[13:8]);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule